// File: doc/BRIEF.md
# Write-Intensity Block Classifier

This block keeps a small, fully associative table of recently written-back memory blocks. For each block it records whether that block is write-intensive (active) or not (inert). Every write-back presents the block's address tag. The table finds the tag or inserts it, updates the entry's reference flags, and one cycle later reports an active/inert decision. The encryption path uses that decision to choose between a keystream-reuse cipher mode and a plain block mode.

A free-running cycle counter marks period boundaries. On each boundary, every entry moves its current-period flag into its previous-period flag and clears the current one. An entry becomes active when it is written twice within one period. An active entry falls back to inert when it is written after a period in which it was not written.

When the table is full, a round-robin victim is replaced. If the victim was active, the block must change cipher mode, so a re-encryption request carrying the victim's tag is raised. The request is held until it is acknowledged, and new writes stall meanwhile.

Top module: `wic_table`

## Requirements
- R1: After reset, res_valid and reenc_valid are 0, wr_ready is 1, and every entry is invalid, so the first write of any tag reports inert.
- R2: A write accepted at a clock edge (wr_valid and wr_ready high) gives res_valid=1 in the next cycle. A write whose tag misses inserts an entry with current flag 1, previous flag 0 and active flag 0, and reports res_active=0.
- R3: A hit on an inert entry whose current flag is already 1 makes the entry active, and reports res_active=1.
- R4: A hit on an active entry whose previous flag is 0 makes it inert, and reports res_active=0. Every hit sets the current flag.
- R5: period_tick is high for exactly one cycle in every 2^PERIOD_LOG2 cycles. It is high in the cycle where the low PERIOD_LOG2 bits of the cycle count (0 in the first cycle after reset) are all ones.
- R6: A miss fills the lowest-numbered invalid slot. When no slot is invalid, the miss replaces the slot at a round-robin pointer. The pointer starts at 0 and advances by one, wrapping, on each replacement.
- R7: Replacing an active entry sets reenc_valid in the next cycle, with reenc_tag equal to the replaced tag. Both hold until reenc_ack is seen high at a clock edge. While reenc_valid is 1, wr_ready is 0 and no write is taken.
- R8: Replacing an inert entry raises no re-encryption request.
- R9: At a period boundary, every entry copies its current flag into its previous flag and clears its current flag. A write in the boundary cycle is judged against the flags as already aged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write-back present |
| wr_tag | input | TAG_W | Block address tag of the write-back |
| wr_ready | output | 1 | Write can be taken this cycle |
| res_valid | output | 1 | Decision valid (one cycle after an accepted write) |
| res_active | output | 1 | 1 = write-intensive, 0 = inert |
| period_tick | output | 1 | One-cycle period boundary pulse |
| reenc_valid | output | 1 | Re-encryption request pending |
| reenc_tag | output | TAG_W | Tag of the evicted active block |
| reenc_ack | input | 1 | Acknowledge of the pending request |

## Verification
A wrong flag in an entry shows up on res_active at the next write to that tag, one cycle after the write is accepted. A wrong tag or a wrong victim choice shows up as a false hit or miss on later decisions, or as a reenc_tag that differs from the block actually displaced, one cycle after the eviction. Errors in ageing show up on the first write after a boundary, when a block that should fall back to inert reports active, or the reverse.

// File: rtl/wic_table.sv
module wic_table #(
  parameter int ENTRIES     = 4,
  parameter int TAG_W       = 16,
  parameter int PERIOD_LOG2 = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  input  logic [TAG_W-1:0] wr_tag,
  output logic             wr_ready,
  output logic             res_valid,
  output logic             res_active,
  output logic             period_tick,
  output logic             reenc_valid,
  output logic [TAG_W-1:0] reenc_tag,
  input  logic             reenc_ack
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [TAG_W-1:0]       tag_q [ENTRIES];
  logic [ENTRIES-1:0]     vld_q, prv_q, cur_q, act_q;
  logic [ENTRIES-1:0]     prv_a, cur_a, hit;
  logic [PERIOD_LOG2-1:0] cnt_q;
  logic [IDX_W-1:0]       rr_q, hit_idx, free_idx, slot;
  logic                   hit_any, free_any, fire, evict, new_act;

  assign period_tick = &cnt_q;
  assign prv_a       = period_tick ? cur_q : prv_q;
  assign cur_a       = period_tick ? '0 : cur_q;
  assign wr_ready    = !reenc_valid;
  assign fire        = wr_valid && wr_ready;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign hit[i] = vld_q[i] && (tag_q[i] == wr_tag);
  end

  always_comb begin
    hit_any  = 1'b0;
    hit_idx  = '0;
    free_any = 1'b0;
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hit[i]) begin
        hit_any = 1'b1;
        hit_idx = IDX_W'(i);
      end
      if (!vld_q[i]) begin
        free_any = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
  end

  assign slot  = hit_any ? hit_idx : (free_any ? free_idx : rr_q);
  assign evict = fire && !hit_any && !free_any;

  always_comb begin
    new_act = 1'b0;
    if (hit_any) begin
      if (cur_a[hit_idx] && !act_q[hit_idx])
        new_act = 1'b1;
      else if (act_q[hit_idx] && !prv_a[hit_idx])
        new_act = 1'b0;
      else
        new_act = act_q[hit_idx];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      vld_q <= '0;
      prv_q <= '0;
      cur_q <= '0;
      act_q <= '0;
      rr_q  <= '0;
      for (int i = 0; i < ENTRIES; i++) tag_q[i] <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      prv_q <= prv_a;
      cur_q <= cur_a;
      if (fire) begin
        vld_q[slot] <= 1'b1;
        tag_q[slot] <= wr_tag;
        cur_q[slot] <= 1'b1;
        act_q[slot] <= new_act;
        if (!hit_any) prv_q[slot] <= 1'b0;
      end
      if (evict) rr_q <= (rr_q == LAST) ? '0 : rr_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid   <= 1'b0;
      res_active  <= 1'b0;
      reenc_valid <= 1'b0;
      reenc_tag   <= '0;
    end else begin
      res_valid  <= fire;
      res_active <= fire ? new_act : 1'b0;
      if (evict && act_q[rr_q]) begin
        reenc_valid <= 1'b1;
        reenc_tag   <= tag_q[rr_q];
      end else if (reenc_ack) begin
        reenc_valid <= 1'b0;
      end
    end
  end

  AST_STALL_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    reenc_valid |-> !wr_ready) else $error("stall"); // R7
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (reenc_valid && !reenc_ack) |=> (reenc_valid && $stable(reenc_tag))) else $error("held"); // R7
  AST_RESULT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> res_valid) else $error("result"); // R2
  AST_TICK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    period_tick |=> !period_tick) else $error("tick"); // R5
  AST_ONE_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit)) else $error("dup"); // R6
endmodule

// File: tb/wic_table_tb.sv
module wic_table_tb;
  localparam int N = 4;
  localparam int TW = 16;
  localparam int PL = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0;
  logic [TW-1:0] wr_tag = '0;
  logic reenc_ack = 1'b0;
  logic wr_ready, res_valid, res_active, period_tick, reenc_valid;
  logic [TW-1:0] reenc_tag;

  always #10 clk = ~clk;

  wic_table #(.ENTRIES(N), .TAG_W(TW), .PERIOD_LOG2(PL)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_tag(wr_tag),
    .wr_ready(wr_ready), .res_valid(res_valid), .res_active(res_active),
    .period_tick(period_tick), .reenc_valid(reenc_valid),
    .reenc_tag(reenc_tag), .reenc_ack(reenc_ack));

  int total = 0, bad = 0, bcyc = 0;
  bit done = 0;
  bit [TW-1:0] m_tag [N];
  bit [N-1:0] m_v, m_p, m_c, m_w;
  int m_rr = 0;
  bit e_rv = 0, e_ra = 0, e_qv = 0;
  bit [TW-1:0] e_qt = '0;
  string ra_lab = "R2", q_lab = "R7";

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", rq, act, exp, bcyc);
    end
  endtask

  function automatic bit exp_tick(input int c);
    return (c % (1 << PL)) == (1 << PL) - 1;
  endfunction

  task automatic step(input bit v, input bit [TW-1:0] t, input bit ack);
    bit tk, fire, hit;
    int hi, fi, sl;
    bit [N-1:0] pa, ca;
    check(period_tick == exp_tick(bcyc), "R5", period_tick, exp_tick(bcyc));
    check(res_valid == e_rv, "R2", res_valid, e_rv);
    if (e_rv) check(res_active == e_ra, ra_lab, res_active, e_ra);
    check(reenc_valid == e_qv, q_lab, reenc_valid, e_qv);
    if (e_qv) check(reenc_tag == e_qt, "R6", reenc_tag, e_qt);
    check(wr_ready == !e_qv, "R7", wr_ready, !e_qv);
    wr_valid = v; wr_tag = t; reenc_ack = ack;
    tk = exp_tick(bcyc);
    pa = tk ? m_c : m_p;
    ca = tk ? '0 : m_c;
    fire = v && !e_qv;
    if (e_qv && ack) e_qv = 0;
    e_rv = fire; e_ra = 0;
    if (fire) begin
      hit = 0; hi = 0; fi = -1;
      for (int i = N - 1; i >= 0; i--) begin
        if (m_v[i] && m_tag[i] == t) begin hit = 1; hi = i; end
        if (!m_v[i]) fi = i;
      end
      if (hit) begin
        sl = hi;
        ra_lab = tk ? "R9" : "R3";
        if (ca[hi] && !m_w[hi]) e_ra = 1;
        else if (m_w[hi] && !pa[hi]) begin e_ra = 0; ra_lab = tk ? "R9" : "R4"; end
        else e_ra = m_w[hi];
      end else begin
        ra_lab = "R2";
        if (fi >= 0) sl = fi;
        else begin
          sl = m_rr;
          if (m_w[sl]) begin e_qv = 1; e_qt = m_tag[sl]; q_lab = "R7"; end
          else q_lab = "R8";
          m_rr = (m_rr + 1) % N;
        end
        pa[sl] = 0;
      end
      m_v[sl] = 1; m_tag[sl] = t; ca[sl] = 1; m_w[sl] = e_ra;
    end
    m_p = pa; m_c = ca;
    @(negedge clk);
    bcyc++;
  endtask

  task automatic idle_to_tick();
    while (!exp_tick(bcyc)) step(0, '0, 0);
  endtask

  initial begin
    m_v = '0; m_p = '0; m_c = '0; m_w = '0;
    for (int i = 0; i < N; i++) m_tag[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check(res_valid == 0 && reenc_valid == 0 && wr_ready == 1, "R1", {res_valid, reenc_valid, wr_ready}, 3'b001);
    step(1, 16'h00A1, 0);
    step(1, 16'h00A1, 0);
    step(0, '0, 0);
    idle_to_tick();
    step(0, '0, 0);
    step(1, 16'h00B2, 0);
    step(1, 16'h00C3, 0);
    step(1, 16'h00D4, 0);
    step(1, 16'h00E5, 0);
    for (int i = 0; i < 3; i++) step(1, 16'h00F6, 0);
    step(0, '0, 1);
    step(1, 16'h0107, 0);
    step(0, '0, 0);
    idle_to_tick();
    step(1, 16'h00E5, 0);
    step(1, 16'h00E5, 0);
    idle_to_tick(); step(0, '0, 0);
    idle_to_tick();
    step(1, 16'h00E5, 0);
    step(0, '0, 0);
    idle_to_tick();
    step(1, 16'h0107, 0);
    for (int k = 0; k < 4000; k++) begin
      bit v, a;
      bit [TW-1:0] t;
      v = ($urandom % 2) == 0;
      a = ($urandom % 3) == 0;
      t = 16'h0200 + 16'($urandom % 6);
      step(v, t, a);
    end
    step(0, '0, 1);
    step(0, '0, 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    #(20 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog R1 actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule